// File: doc/BRIEF.md
# Command-Word Serial Peripheral Shift Engine

This block is the shifting core of a serial peripheral master. Software writes the data to send into a transmit register, then writes one 32-bit command word. The command names the peripheral (three chip-select lines, active low), the level the serial clock rests at, the number of bits to move (1 to 32) and whether the transaction ends with this command. The engine then clocks that many bits out on the data-out pin, most significant counted bit first. At the same time it gathers the same number of bits from the data-in pin into a receive register that is always visible on the read port.

A transaction of any total length, in words of any size, is built from several commands. Every command but the last leaves its terminate flag clear, so the chip select stays asserted between them. The last command sets the flag, and the line is released when its final bit is done. The serial clock runs at a fixed fraction of the system clock, set by a parameter.

The sequencer has four states. IDLE waits for a valid command (transition IDLE->SETUP on acceptance). SETUP holds the clock at its rest level for one half period with the chip select asserted (SETUP->LEAD on the half-period tick). LEAD drives the clock to its active level and presents a data bit (LEAD->TRAIL on the tick). TRAIL returns the clock to rest and samples the input (TRAIL->LEAD on the tick while bits remain, TRAIL->IDLE on the tick after the last bit, releasing the chip select if the command asked for it).

Top module: `cmd_spi_shifter`

## Requirements
- R1: Out of reset, cs_n is 3'b111, sclk is 0, mosi is 0, busy is 0 and rd_data is 0.
- R2: A write with wr_addr=0 starts an operation when wr_data bit 31 (enable) is 1 and bits 6:0 (count) lie in 1..32. busy goes high on the following clock and stays high until the operation ends.
- R3: Command bits 30, 29 and 28 drive cs_n[2], cs_n[1] and cs_n[0] low for the operation. A set bit asserts its line.
- R4: Command bit 27 is the rest level of sclk. sclk takes it the clock after acceptance, holds it before the first bit, and is back at it when busy falls.
- R5: A write with wr_addr=1 loads the transmit register. Bit count-1 of it goes out first on mosi, and bit 0 goes out last.
- R6: The receive register clears at acceptance, and each sampled miso bit enters at bit 0 while earlier bits move up. After the operation, rd_data holds the received bits in its low count bits, with the upper bits zero.
- R7: mosi changes only as sclk leaves its rest level. miso is sampled as sclk returns to rest.
- R8: Each operation makes exactly count pulses on sclk (2*count edges). Every sclk level, including the setup interval, lasts HALF_DIV system clocks.
- R9: When command bit 26 (terminate) is 1, cs_n returns to 3'b111 as busy falls. When it is 0, the selected lines stay low after the operation.
- R10: A command with the enable bit 0, a count of 0 or a count above 32 is ignored: busy stays low and sclk, cs_n and mosi keep their values.
- R11: A command write while busy is ignored and does not change the running operation.
- R12: Command bits 25:7 have no effect on the operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the command word, 1 the transmit data |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Receive register |
| busy | output | 1 | Operation in progress |
| sclk | output | 1 | Serial clock |
| cs_n | output | 3 | Chip selects, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions assume that reset is held long enough to clear every register, and that miso changes only while sclk is at its active level, so that it is stable at the sampling edge. The bench's slave model follows that assumption: it updates miso only at the sample after it sees a leading edge. The ignore rule for commands is checked on the write port itself, and command writes are spaced a whole clock apart with no other write in flight.

// File: rtl/cspi_pkg.sv
package cspi_pkg;

    localparam int DATA_W  = 32;
    localparam int CNT_W   = 7;
    localparam int NUM_CS  = 3;
    localparam int RSVD_W  = DATA_W - 1 - NUM_CS - 2 - CNT_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_LEAD  = 2'd2,
        ST_TRAIL = 2'd3
    } cspi_state_e;

    // Command word layout, most significant field first.
    typedef struct packed {
        logic              go;
        logic [NUM_CS-1:0] sel;
        logic              rest_lvl;
        logic              last;
        logic [RSVD_W-1:0] spare;
        logic [CNT_W-1:0]  nbits;
    } cspi_cmd_t;

endpackage

// File: rtl/cspi_clkdiv.sv
module cspi_clkdiv #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cspi_cmd_decode.sv
module cspi_cmd_decode
    import cspi_pkg::*;
(
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output logic              start,
    output logic              tx_we,
    output logic [NUM_CS-1:0] sel,
    output logic              rest_lvl,
    output logic              last,
    output logic [CNT_W-1:0]  nbits
);
    localparam logic [CNT_W-1:0] MAX_BITS = CNT_W'(DATA_W);

    cspi_cmd_t cmd;
    logic      cnt_ok;

    assign cmd      = cspi_cmd_t'(wr_data);
    assign cnt_ok   = (cmd.nbits != '0) && (cmd.nbits <= MAX_BITS);
    assign start    = wr_en && !wr_addr && !busy && cmd.go && cnt_ok;
    assign tx_we    = wr_en && wr_addr;
    assign sel      = cmd.sel;
    assign rest_lvl = cmd.rest_lvl;
    assign last     = cmd.last;
    assign nbits    = cmd.nbits;
endmodule

// File: rtl/cspi_shifter.sv
module cspi_shifter
    import cspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [CNT_W-1:0]  nbits,
    input  logic              advance,
    input  logic              sample,
    input  logic              din,
    output logic              next_bit,
    output logic [DATA_W-1:0] rx_word
);
    logic [DATA_W-1:0] tx_sh_q;
    logic [DATA_W-1:0] rx_sh_q;
    logic [CNT_W-1:0]  align;

    // Left-justify so that bit nbits-1 sits at the top.
    assign align    = CNT_W'(DATA_W) - nbits;
    assign next_bit = tx_sh_q[DATA_W-1];
    assign rx_word  = rx_sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh_q <= '0;
        end else if (load) begin
            tx_sh_q <= tx_word << align;
        end else if (advance) begin
            tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh_q <= '0;
        end else if (load) begin
            rx_sh_q <= '0;
        end else if (sample) begin
            rx_sh_q <= {rx_sh_q[DATA_W-2:0], din};
        end
    end
endmodule

// File: rtl/cmd_spi_shifter.sv
module cmd_spi_shifter
    import cspi_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              sclk,
    output logic [NUM_CS-1:0] cs_n,
    output logic              mosi,
    input  logic              miso
);
    cspi_state_e       state_q, state_d;
    logic              start, tx_we, tick;
    logic [NUM_CS-1:0] cmd_sel;
    logic              cmd_rest, cmd_last;
    logic [CNT_W-1:0]  cmd_nbits;
    logic [DATA_W-1:0] tx_reg_q;
    logic [CNT_W-1:0]  left_q;
    logic              rest_q, last_q, sclk_q, mosi_q;
    logic [NUM_CS-1:0] sel_q;
    logic              advance, sample, next_bit, more;

    cspi_cmd_decode u_dec (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .busy     (busy),
        .start    (start),
        .tx_we    (tx_we),
        .sel      (cmd_sel),
        .rest_lvl (cmd_rest),
        .last     (cmd_last),
        .nbits    (cmd_nbits)
    );

    cspi_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    assign more    = (left_q != '0);
    assign advance = tick && ((state_q == ST_SETUP) || (state_q == ST_TRAIL && more));
    assign sample  = tick && (state_q == ST_LEAD);

    cspi_shifter u_sh (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .tx_word  (tx_reg_q),
        .nbits    (cmd_nbits),
        .advance  (advance),
        .sample   (sample),
        .din      (miso),
        .next_bit (next_bit),
        .rx_word  (rd_data)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_SETUP;
            ST_SETUP: if (tick)  state_d = ST_LEAD;
            ST_LEAD:  if (tick)  state_d = ST_TRAIL;
            ST_TRAIL: if (tick)  state_d = more ? ST_LEAD : ST_IDLE;
            default:             state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transmit data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     tx_reg_q <= '0;
        else if (tx_we) tx_reg_q <= wr_data;
    end

    // Output and counter registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            mosi_q <= 1'b0;
            sel_q  <= '0;
            rest_q <= 1'b0;
            last_q <= 1'b0;
            left_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        sclk_q <= cmd_rest;
                        rest_q <= cmd_rest;
                        last_q <= cmd_last;
                        sel_q  <= cmd_sel;
                        left_q <= cmd_nbits;
                    end
                end
                ST_SETUP: begin
                    if (tick) begin
                        sclk_q <= ~rest_q;
                        mosi_q <= next_bit;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        sclk_q <= rest_q;
                        left_q <= left_q - 1'b1;
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        if (more) begin
                            sclk_q <= ~rest_q;
                            mosi_q <= next_bit;
                        end else if (last_q) begin
                            sel_q <= '0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_n[g] = ~sel_q[g];
    end

    assign busy = (state_q != ST_IDLE);
    assign sclk = sclk_q;
    assign mosi = mosi_q;
endmodule

// File: rtl/cspi_checker.sv
module cspi_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        wr_addr,
    input logic [31:0] wr_data,
    input logic        busy,
    input logic        sclk,
    input logic [2:0]  cs_n,
    input logic        mosi
);
    // R3 / R11: chip selects stay put for the whole operation
    a_r11_cs_steady_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(cs_n)));

    // R4: no clock activity while idle, except the rest level taken at acceptance
    a_r4_sclk_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (busy || $stable(sclk)));

    // R7: data out changes only together with a clock transition
    a_r7_mosi_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi) |-> !$stable(sclk));

    // R10: invalid commands never start an operation
    a_r10_bad_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr && !busy &&
         (!wr_data[31] || wr_data[6:0] == 7'd0 || wr_data[6:0] > 7'd32)) |=> !busy);

    // R9: chip selects only change while idle or when leaving an operation
    a_r9_cs_release_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && !busy) |-> (cs_n == 3'b111 || $stable(cs_n)));
endmodule

bind cmd_spi_shifter cspi_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .busy    (busy),
    .sclk    (sclk),
    .cs_n    (cs_n),
    .mosi    (mosi)
);

// File: tb/cmd_spi_shifter_tb_top.sv
module cmd_spi_shifter_tb_top;
    localparam int HALF_DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        busy, sclk, mosi;
    logic [2:0]  cs_n;
    logic        miso = 1'b0;

    always #10 clk = ~clk;

    cmd_spi_shifter #(.HALF_DIV(HALF_DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_data(rd_data), .busy(busy), .sclk(sclk),
        .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    typedef struct {
        logic [31:0] tx;
        logic [31:0] slave;
        int          cnt;
        logic [2:0]  sel;
        logic        rest;
        logic        term;
    } item_t;

    item_t exp_q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 0;

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mask(int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    endfunction

    function automatic logic [31:0] mk_cmd(bit en, logic [2:0] sel, bit rest, bit term,
                                           logic [18:0] spare, logic [6:0] n);
        return {en, sel, rest, term, spare, n};
    endfunction

    task automatic bus_wr(bit addr, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: push expectation, then issue the command
    task automatic start_cmd(logic [31:0] tx, logic [31:0] sl, int n, logic [2:0] sel,
                             bit rest, bit term, logic [18:0] spare);
        item_t it;
        it.tx = tx; it.slave = sl; it.cnt = n; it.sel = sel; it.rest = rest; it.term = term;
        exp_q.push_back(it);
        bus_wr(1'b1, tx);
        bus_wr(1'b0, mk_cmd(1'b1, sel, rest, term, spare, 7'(n)));
    endtask

    task automatic wait_done();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_cmd(logic [31:0] tx, logic [31:0] sl, int n, logic [2:0] sel,
                           bit rest, bit term, logic [18:0] spare);
        start_cmd(tx, sl, n, sel, rest, term, spare);
        wait_done();
    endtask

    task automatic bad_cmd(logic [31:0] c, string req);
        logic [2:0] cs0;
        logic       s0, m0;
        cs0 = cs_n; s0 = sclk; m0 = mosi;
        bus_wr(1'b0, c);
        repeat (6) @(negedge clk);
        check(busy == 1'b0, req, {31'd0, busy}, 32'd0);
        check({cs_n, sclk, mosi} == {cs0, s0, m0}, req, {27'd0, cs_n, sclk, mosi}, {27'd0, cs0, s0, m0});
    endtask

    // Monitor and slave model
    item_t       cur;
    bit          prev_busy = 0, prev_sclk = 0, bad_int = 0;
    int          cyc = 0, edges = 0, bitn = 0;
    logic [31:0] cap = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !prev_busy) begin
                cur = exp_q[0];
                bitn = cur.cnt; cap = '0; edges = 0; cyc = 0; bad_int = 0;
                check(sclk == cur.rest, "R4 rest level at start", {31'd0, sclk}, {31'd0, cur.rest});
            end else if (busy) begin
                cyc++;
                if (sclk != prev_sclk) begin
                    edges++;
                    if (cyc != HALF_DIV) bad_int = 1;
                    cyc = 0;
                    if (sclk != cur.rest) begin
                        bitn--;
                        if (bitn >= 0) miso = cur.slave[bitn];
                        if (edges == 1)
                            check(cs_n == ~cur.sel, "R3 chip select", {29'd0, cs_n}, {29'd0, ~cur.sel});
                    end else begin
                        cap = {cap[30:0], mosi};
                    end
                end
            end
            if (!busy && prev_busy) begin
                cur = exp_q.pop_front();
                check(cap == (cur.tx & mask(cur.cnt)), "R5 mosi word", cap, cur.tx & mask(cur.cnt));
                check(rd_data == (cur.slave & mask(cur.cnt)), "R6 rx word", rd_data, cur.slave & mask(cur.cnt));
                check(edges == 2 * cur.cnt, "R8 edge count", edges, 2 * cur.cnt);
                check(bad_int == 0, "R8 half period", {31'd0, bad_int}, 32'd0);
                check(sclk == cur.rest, "R4 rest level at end", {31'd0, sclk}, {31'd0, cur.rest});
                check(cs_n == (cur.term ? 3'b111 : ~cur.sel), "R9 chip select after",
                      {29'd0, cs_n}, {29'd0, cur.term ? 3'b111 : ~cur.sel});
            end
        end
        prev_busy = busy;
        prev_sclk = sclk;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check({cs_n, sclk, mosi, busy} == 6'b111000, "R1 reset pins", {26'd0, cs_n, sclk, mosi, busy}, 32'h38);
        check(rd_data == 32'd0, "R1 reset rx", rd_data, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 basic 8-bit on cs0, rest low, terminate
        run_cmd(32'h0000_00A5, 32'h0000_003C, 8, 3'b001, 1'b0, 1'b1, 19'd0);
        // R2 32-bit boundary on cs1, rest high
        run_cmd(32'hDEAD_BEEF, 32'h1234_5678, 32, 3'b010, 1'b1, 1'b1, 19'd0);
        // R2 single-bit boundary on cs2 (upper tx bits must not leak)
        run_cmd(32'hFFFF_FFFE, 32'h0000_0001, 1, 3'b100, 1'b0, 1'b1, 19'd0);
        // R9 back-to-back: hold then release
        run_cmd(32'h0000_1B3D, 32'h0000_0AC5, 13, 3'b001, 1'b0, 1'b0, 19'd0);
        check(cs_n == 3'b110, "R9 held between commands", {29'd0, cs_n}, 32'd6);
        run_cmd(32'h0005_A5A5, 32'h0006_0F0F, 19, 3'b001, 1'b0, 1'b1, 19'd0);
        // R12 spare bits set
        run_cmd(32'h00C3_3C96, 32'h0081_7E42, 24, 3'b100, 1'b1, 1'b1, 19'h5A5A5);

        // R10 ignored commands (sclk rests high now; these try rest low)
        bad_cmd(mk_cmd(1'b0, 3'b001, 1'b0, 1'b1, 19'd0, 7'd8),  "R10 enable clear");
        bad_cmd(mk_cmd(1'b1, 3'b010, 1'b0, 1'b1, 19'd0, 7'd0),  "R10 count zero");
        bad_cmd(mk_cmd(1'b1, 3'b001, 1'b0, 1'b1, 19'd0, 7'd33), "R10 count above 32");

        // R11 write while busy
        start_cmd(32'h0000_9C71, 32'h0000_6E2B, 16, 3'b010, 1'b0, 1'b1, 19'd0);
        repeat (5) @(negedge clk);
        bus_wr(1'b0, mk_cmd(1'b1, 3'b001, 1'b1, 1'b0, 19'd0, 7'd5));
        wait_done();
        repeat (10) @(negedge clk);
        check(busy == 1'b0, "R11 no second operation", {31'd0, busy}, 32'd0);
        check(cs_n == 3'b111, "R11 cs untouched", {29'd0, cs_n}, 32'd7);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule